// File: doc/BRIEF.md
# Halt Wake-up and Reset Controller

This block sequences low-power halt, wake-up and reset for a small microcontroller core. Instruction decode requests halt and watchdog clears. The block answers with a run-enable gate for the core and with reset strobes. A full reset initialises the machine. A warm reset reloads only the program counter and stack pointer. Two status flags, time-out and power-down, let software tell afterwards why the core restarted.

While halted, the core wakes on the external reset pin, on a watchdog overflow, on a pending interrupt, or on a falling edge of any input-port bit whose wake mask bit is set. A static configuration input says whether the clock source is a crystal or an RC oscillator. With a crystal, every halt wake-up and every release of the reset pin is followed by a start-up wait of a parameterised number of cycles (1024 by default) before the core runs. With an RC oscillator the core runs on the next cycle. On the first run cycle after a wake-up, the block pulses exactly one of three outputs: warm reset, take interrupt, or resume at the next instruction.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While the power-on input is low, to_flag and pd_flag read 0, full_rst is 1 and run_en is 0. After release, with the reset pin high and RC selected, run_en is 1 after one clock.
- R2: A halt request while running sets pd_flag to 1, clears to_flag, sets halted, drops run_en and pulses wdt_clr for exactly one cycle. While halted, pd_flag is 1 and to_flag is 0.
- R3: A watchdog-clear strobe while running clears pd_flag, leaves to_flag unchanged and pulses wdt_clr for one cycle.
- R4: A watchdog overflow while running sets to_flag and leaves pd_flag unchanged. For the one following cycle, full_rst is 1 and run_en is 0.
- R5: A watchdog overflow while halted sets to_flag and keeps pd_flag at 1, so {to,pd}=11. On the first run cycle it pulses warm_rst for one cycle, and full_rst stays 0.
- R6: While the reset pin is low (one clock of latency), full_rst is 1, run_en is 0 and halted is 0. Neither flag changes, so a reset from halt reads {to,pd}=01.
- R7: Port pins pass through a two-stage synchroniser. In halt, a high-to-low transition on bit i with wake_mask[i]=1 wakes the core on the third clock after the pin falls, and resume_next pulses. A falling edge on a masked-off bit does not wake the core.
- R8: A pending interrupt wakes the core from halt. take_irq pulses if irq_en=1 and stack_full=0, otherwise resume_next pulses. Both are sampled in the wake cycle.
- R9: With xtal_sel=1, run_en stays 0 for DLY_CYC cycles after a halt wake-up or a reset-pin release, and goes to 1 on the cycle after those.
- R10: With xtal_sel=0, run_en is 1 on the cycle right after the wake-up or the reset-pin release.
- R11: When wake sources coincide, the reset pin beats the watchdog, the watchdog beats the interrupt, and the interrupt beats the port edge.
- R12: At most one of warm_rst, take_irq and resume_next is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| xtal_sel | input | 1 | 1 = crystal oscillator (start-up wait), 0 = RC |
| halt_req | input | 1 | Halt instruction strobe |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| port_in | input | PORT_W | Asynchronous input-port pins |
| wake_mask | input | PORT_W | Per-bit falling-edge wake enable |
| irq_pend | input | 1 | Interrupt pending |
| irq_en | input | 1 | Pending interrupt enabled |
| stack_full | input | 1 | Call stack full |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| halted | output | 1 | Core is in halt |
| full_rst | output | 1 | Full machine reset |
| warm_rst | output | 1 | Program counter and stack pointer reload |
| wdt_clr | output | 1 | Clear watchdog counter and prescaler |
| run_en | output | 1 | Core may execute this cycle |
| take_irq | output | 1 | Enter interrupt response on resume |
| resume_next | output | 1 | Continue at next instruction on resume |

## Verification
The assertions watch, on every cycle, the relations that hold in any state. They check that the flags stay 1/0 throughout halt, that halt entry brings a watchdog clear, and that the reset pin forces full reset without touching the flags. They also check that a watchdog overflow while running raises time-out and reset, that a crystal wake-up holds the core off while an RC wake-up releases it at once, and that the resume strobes are mutually exclusive. Only the bench scenarios can show which strobe follows a given wake source and status, the two-stage latency of the port edge, the masking of single port bits, the exact length of the crystal wait, and the priority order when sources coincide.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {ST_RST, ST_RUN, ST_HALT, ST_DLY} hwc_st_e;

  typedef enum logic [1:0] {WK_NONE, WK_WDT, WK_IRQ, WK_PORT} hwc_wake_e;

  // Interrupt response is taken only when enabled and the stack has room.
  function automatic logic irq_accept(input logic en, input logic full);
    return en & ~full;
  endfunction

  // Fixed wake priority: watchdog, then interrupt, then port edge.
  function automatic hwc_wake_e pick_wake(input logic wdt, input logic irq,
                                          input logic port);
    if (wdt)       return WK_WDT;
    else if (irq)  return WK_IRQ;
    else if (port) return WK_PORT;
    else           return WK_NONE;
  endfunction

endpackage

// File: rtl/hwc_port_wake.sv
module hwc_port_wake #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin,
  input  logic [PORT_W-1:0] mask,
  output logic              edge_any
);
  logic [PORT_W-1:0] s1_q, s2_q, prev_q;
  logic [PORT_W-1:0] fall_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign fall_vec[i] = prev_q[i] & ~s2_q[i] & mask[i];
  end

  assign edge_any = |fall_vec;
endmodule

// File: rtl/hwc_dly.sv
module hwc_dly #(
  parameter int DLY_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(DLY_CYC) + 1;
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!active)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int DLY_CYC = 1024
) (
  input  logic              clk,
  input  logic              pwr_on_n,
  input  logic              rst_pin_n,
  input  logic              xtal_sel,
  input  logic              halt_req,
  input  logic              clr_wdt,
  input  logic              wdt_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] wake_mask,
  input  logic              irq_pend,
  input  logic              irq_en,
  input  logic              stack_full,
  output logic              to_flag,
  output logic              pd_flag,
  output logic              halted,
  output logic              full_rst,
  output logic              warm_rst,
  output logic              wdt_clr,
  output logic              run_en,
  output logic              take_irq,
  output logic              resume_next
);
  hwc_st_e   st_q;
  hwc_wake_e cause_q;
  hwc_wake_e wake_src;
  logic      port_edge, dly_done, wake_any, first_run;
  logic      resume_q, accept_q, wdt_clr_q, wdt_rst_q;

  hwc_port_wake #(.PORT_W(PORT_W)) u_port (
    .clk(clk), .rst_n(pwr_on_n), .pin(port_in), .mask(wake_mask),
    .edge_any(port_edge)
  );

  hwc_dly #(.DLY_CYC(DLY_CYC)) u_dly (
    .clk(clk), .rst_n(pwr_on_n), .active(st_q == ST_DLY), .done(dly_done)
  );

  assign wake_src = pick_wake(wdt_ovf, irq_pend, port_edge);
  assign wake_any = (st_q == ST_HALT) && (wake_src != WK_NONE);

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      st_q      <= ST_RST;
      to_flag   <= 1'b0;
      pd_flag   <= 1'b0;
      cause_q   <= WK_NONE;
      resume_q  <= 1'b0;
      accept_q  <= 1'b0;
      wdt_clr_q <= 1'b0;
      wdt_rst_q <= 1'b0;
    end else begin
      wdt_clr_q <= 1'b0;
      wdt_rst_q <= 1'b0;
      if (!rst_pin_n) begin
        st_q     <= ST_RST;
        resume_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RST: st_q <= xtal_sel ? ST_DLY : ST_RUN;
          ST_RUN: begin
            if (resume_q) resume_q <= 1'b0;
            if (!wdt_rst_q) begin
              if (wdt_ovf) begin
                to_flag   <= 1'b1;
                wdt_rst_q <= 1'b1;
              end else if (halt_req) begin
                st_q      <= ST_HALT;
                pd_flag   <= 1'b1;
                to_flag   <= 1'b0;
                wdt_clr_q <= 1'b1;
              end else if (clr_wdt) begin
                pd_flag   <= 1'b0;
                wdt_clr_q <= 1'b1;
              end
            end
          end
          ST_HALT: begin
            if (wake_any) begin
              cause_q  <= wake_src;
              resume_q <= 1'b1;
              accept_q <= irq_accept(irq_en, stack_full);
              if (wake_src == WK_WDT) to_flag <= 1'b1;
              st_q <= xtal_sel ? ST_DLY : ST_RUN;
            end
          end
          ST_DLY: if (dly_done) st_q <= ST_RUN;
          default: st_q <= ST_RST;
        endcase
      end
    end
  end

  assign halted      = (st_q == ST_HALT);
  assign run_en      = (st_q == ST_RUN) && !wdt_rst_q;
  assign full_rst    = (st_q == ST_RST) || wdt_rst_q;
  assign wdt_clr     = wdt_clr_q;
  assign first_run   = run_en && resume_q;
  assign warm_rst    = first_run && (cause_q == WK_WDT);
  assign take_irq    = first_run && (cause_q == WK_IRQ) && accept_q;
  assign resume_next = first_run && ((cause_q == WK_PORT) ||
                                     ((cause_q == WK_IRQ) && !accept_q));
endmodule

// File: rtl/hwc_chk.sv
module hwc_chk (
  input logic clk,
  input logic pwr_on_n,
  input logic rst_pin_n,
  input logic xtal_sel,
  input logic wdt_ovf,
  input logic wake_any,
  input logic halted,
  input logic run_en,
  input logic full_rst,
  input logic to_flag,
  input logic pd_flag,
  input logic wdt_clr,
  input logic warm_rst,
  input logic take_irq,
  input logic resume_next
);
  p_halt_flags_r2: assert property (@(posedge clk) disable iff (!pwr_on_n)
    halted |-> (pd_flag && !to_flag && !run_en));

  p_halt_clear_r2: assert property (@(posedge clk) disable iff (!pwr_on_n)
    $rose(halted) |-> wdt_clr);

  p_wdt_run_r4: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (run_en && wdt_ovf && rst_pin_n) |=> (to_flag && full_rst && !run_en));

  p_pin_full_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !rst_pin_n |=> (full_rst && !run_en && !halted));

  p_pin_flags_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !rst_pin_n |=> ($stable(to_flag) && $stable(pd_flag)));

  p_xtal_hold_r9: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (xtal_sel && wake_any && rst_pin_n) |=> !run_en);

  p_rc_fast_r10: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (!xtal_sel && wake_any && rst_pin_n) |=> run_en);

  p_one_resume_r12: assert property (@(posedge clk) disable iff (!pwr_on_n)
    $onehot0({warm_rst, take_irq, resume_next}));
endmodule

bind halt_wake_ctrl hwc_chk chk_i (
  .clk(clk), .pwr_on_n(pwr_on_n), .rst_pin_n(rst_pin_n), .xtal_sel(xtal_sel),
  .wdt_ovf(wdt_ovf), .wake_any(wake_any), .halted(halted), .run_en(run_en),
  .full_rst(full_rst), .to_flag(to_flag), .pd_flag(pd_flag), .wdt_clr(wdt_clr),
  .warm_rst(warm_rst), .take_irq(take_irq), .resume_next(resume_next)
);

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  localparam int PW  = 8;
  localparam int DLY = 1024;

  logic clk = 1'b0;
  logic pwr_on_n, rst_pin_n, xtal_sel, halt_req, clr_wdt, wdt_ovf;
  logic [PW-1:0] port_in, wake_mask;
  logic irq_pend, irq_en, stack_full;
  logic to_flag, pd_flag, halted, full_rst, warm_rst, wdt_clr, run_en;
  logic take_irq, resume_next;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PW), .DLY_CYC(DLY)) dut_i (
    .clk(clk), .pwr_on_n(pwr_on_n), .rst_pin_n(rst_pin_n), .xtal_sel(xtal_sel),
    .halt_req(halt_req), .clr_wdt(clr_wdt), .wdt_ovf(wdt_ovf),
    .port_in(port_in), .wake_mask(wake_mask), .irq_pend(irq_pend),
    .irq_en(irq_en), .stack_full(stack_full), .to_flag(to_flag),
    .pd_flag(pd_flag), .halted(halted), .full_rst(full_rst),
    .warm_rst(warm_rst), .wdt_clr(wdt_clr), .run_en(run_en),
    .take_irq(take_irq), .resume_next(resume_next)
  );

  function automatic bit exp_take(input bit en, input bit full);
    return en && !full;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_halt();
    halt_req = 1'b1; step(1); halt_req = 1'b0;
  endtask

  initial begin
    pwr_on_n = 0; rst_pin_n = 1; xtal_sel = 0; halt_req = 0; clr_wdt = 0;
    wdt_ovf = 0; port_in = '1; wake_mask = '0; irq_pend = 0; irq_en = 0;
    stack_full = 0;
    void'($urandom(32'h5EED1));
    step(2);
    eq("R1 to", to_flag, 0); eq("R1 pd", pd_flag, 0);
    eq("R1 full_rst", full_rst, 1); eq("R1 run_en", run_en, 0);
    pwr_on_n = 1; step(1);
    eq("R1 run after release", run_en, 1); eq("R1 full_rst off", full_rst, 0);

    // R2 halt entry
    do_halt();
    eq("R2 halted", halted, 1); eq("R2 pd", pd_flag, 1); eq("R2 to", to_flag, 0);
    eq("R2 wdt_clr", wdt_clr, 1); eq("R2 run_en", run_en, 0);
    step(1); eq("R2 wdt_clr one cycle", wdt_clr, 0);

    // R7 masked bit ignored, enabled bit wakes after sync
    wake_mask = 8'h04; port_in[3] = 1'b0; step(4);
    eq("R7 masked bit no wake", halted, 1);
    port_in[3] = 1'b1; step(3);
    port_in[2] = 1'b0; step(2);
    eq("R7 still halted in sync", halted, 1);
    step(1);
    eq("R7 woke run_en", run_en, 1); eq("R7 resume_next", resume_next, 1);
    eq("R7 take_irq", take_irq, 0);
    step(1); eq("R7 pulse ends", resume_next, 0);
    port_in[2] = 1'b1; step(3);

    // R8 interrupt wake variants
    for (int k = 0; k < 3; k++) begin
      do_halt();
      irq_pend = 1; irq_en = (k != 1); stack_full = (k == 2);
      step(1); irq_pend = 0;
      eq("R8 run_en", run_en, 1);
      eq("R8 take_irq", take_irq, exp_take(k != 1, k == 2));
      eq("R8 resume_next", resume_next, !exp_take(k != 1, k == 2));
      step(1);
    end

    // R5 watchdog wake from halt
    do_halt();
    wdt_ovf = 1; step(1); wdt_ovf = 0;
    eq("R5 run_en", run_en, 1); eq("R5 warm_rst", warm_rst, 1);
    eq("R5 to", to_flag, 1); eq("R5 pd", pd_flag, 1); eq("R5 full_rst", full_rst, 0);
    step(1); eq("R5 warm one cycle", warm_rst, 0);

    // R3 clear watchdog
    clr_wdt = 1; step(1); clr_wdt = 0;
    eq("R3 pd cleared", pd_flag, 0); eq("R3 to kept", to_flag, 1);
    eq("R3 wdt_clr", wdt_clr, 1);

    // R4 watchdog while running
    wdt_ovf = 1; step(1); wdt_ovf = 0;
    eq("R4 to", to_flag, 1); eq("R4 pd", pd_flag, 0);
    eq("R4 full_rst", full_rst, 1); eq("R4 run_en", run_en, 0);
    step(1); eq("R4 full_rst one cycle", full_rst, 0); eq("R4 run again", run_en, 1);

    // R6 pin reset while running then while halted
    rst_pin_n = 0; step(2);
    eq("R6 full_rst", full_rst, 1); eq("R6 run_en", run_en, 0);
    eq("R6 to kept", to_flag, 1); eq("R6 pd kept", pd_flag, 0);
    rst_pin_n = 1; step(1); eq("R6 released", run_en, 1);
    do_halt();
    rst_pin_n = 0; wdt_ovf = 1; step(1); wdt_ovf = 0;
    eq("R6 R11 left halt", halted, 0); eq("R6 full_rst halt", full_rst, 1);
    eq("R6 R11 to stays 0", to_flag, 0); eq("R6 pd stays 1", pd_flag, 1);
    rst_pin_n = 1; step(1);
    eq("R10 run after pin release", run_en, 1);

    // R11 watchdog beats interrupt; interrupt beats port edge
    do_halt();
    wdt_ovf = 1; irq_pend = 1; irq_en = 1; stack_full = 0; step(1);
    wdt_ovf = 0; irq_pend = 0;
    eq("R11 warm over irq", warm_rst, 1); eq("R11 no take_irq", take_irq, 0);
    step(1);
    do_halt();
    port_in[2] = 1'b0; step(2); irq_pend = 1; step(1); irq_pend = 0;
    eq("R11 irq over port", take_irq, 1); eq("R11 no resume_next", resume_next, 0);
    port_in[2] = 1'b1; step(3);

    // R9 crystal wait after halt wake and after pin release
    xtal_sel = 1;
    do_halt();
    irq_pend = 1; irq_en = 1; step(1); irq_pend = 0;
    eq("R9 held at start", run_en, 0);
    step(DLY - 1); eq("R9 held at end", run_en, 0);
    step(1); eq("R9 runs", run_en, 1); eq("R9 take_irq", take_irq, 1);
    rst_pin_n = 0; step(2); rst_pin_n = 1; step(DLY);
    eq("R9 pin held", run_en, 0);
    step(1); eq("R9 pin runs", run_en, 1);
    xtal_sel = 0;

    // Random port-mask and interrupt-status trials (R7, R8, R12)
    for (int t = 0; t < 24; t++) begin
      automatic int b = $urandom_range(PW - 1);
      automatic bit en = $urandom_range(1);
      automatic bit full = $urandom_range(1);
      wake_mask = PW'($urandom);
      do_halt();
      port_in[b] = 1'b0; step(3);
      eq("R7 random wake", run_en, int'(wake_mask[b]));
      if (wake_mask[b]) begin
        eq("R7 random resume", resume_next, 1);
      end else begin
        irq_en = en; stack_full = full; irq_pend = 1; step(1); irq_pend = 0;
        eq("R8 random take", take_irq, exp_take(en, full));
        eq("R12 random exclusive", int'(take_irq) + int'(resume_next) + int'(warm_rst), 1);
      end
      step(1);
      port_in[b] = 1'b1; step(3);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule